// File: doc/BRIEF.md
# MII Receive Byte Assembler

This block sits on the receive side of a 10/100 Ethernet MAC. It runs on the receive clock that the PHY supplies and samples the 4-bit receive bus on every rising edge while data-valid is high. Consecutive nibbles are paired into bytes, least significant nibble first. The block hunts for the start-of-frame delimiter in the assembled stream. Everything up to and including the first delimiter is dropped, so the downstream frame parser sees the destination address as its first byte.

Each forwarded byte comes with a one-clock valid strobe. A one-clock start pulse marks the delimiter, and a one-clock end pulse marks the fall of data-valid. The PHY's receive-error line is passed on as a registered flag. Frame check sequence verification, collision and carrier handling, and transmit are left to other blocks.

Top module: `mii_rx_assembler`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, data_o, valid_o, frame_start_o, frame_end_o and rx_error_o are all 0.
- R2: A byte is built from two nibbles sampled on consecutive rising edges with rx_dv_i high: the first becomes bits 3:0 and the second becomes bits 7:4.
- R3: valid_o is high for exactly one cycle, the cycle after the edge on which the second nibble is sampled, so it never stays high on two consecutive cycles.
- R4: Bytes assembled before the first 0xD5 of a frame (preamble 0x55 or any other value) are never presented with valid_o.
- R5: The first assembled byte equal to 0xD5 in a frame raises frame_start_o for one cycle (timed like valid_o) and is itself not output.
- R6: After the delimiter, every byte is forwarded, including further bytes equal to 0xD5.
- R7: On the first edge where rx_dv_i is sampled low after being sampled high, frame_end_o is high for the next cycle only. The nibble position and the delimiter-seen state are cleared, so the next frame needs its own 0xD5.
- R8: A single nibble left over when rx_dv_i falls is discarded. No byte is output for it, and the next frame starts on a fresh low nibble.
- R9: rx_error_o equals rx_er_i as sampled on the previous rising edge.
- R10: A frame that never carries 0xD5 produces no valid_o and no frame_start_o, but still produces its frame_end_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock supplied by the PHY |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 4 | Receive data nibble |
| rx_dv_i | input | 1 | Receive data valid |
| rx_er_i | input | 1 | Receive error from the PHY |
| data_o | output | 8 | Assembled frame byte |
| valid_o | output | 1 | One-cycle strobe for data_o |
| frame_start_o | output | 1 | Pulse when the delimiter is found |
| frame_end_o | output | 1 | Pulse when data-valid falls |
| rx_error_o | output | 1 | Registered receive error |

## Verification
Frames are sent with a full seven-byte preamble, with a short preamble, and with stray non-preamble bytes ahead of the delimiter. These separate a search for the delimiter value from a fixed byte count. Payloads carrying 0xD5 show whether the delimiter search is turned off once it has matched. Back-to-back frames show whether that state clears at the end of each frame. A frame that ends on an odd nibble count, followed by a normal frame, shows whether partial bytes are dropped and nibble alignment is restored. A delimiter-free frame and error bursts during payload check the end pulse and the error path on their own.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam int unsigned NIBBLE_W  = 4;
  localparam int unsigned BYTE_W    = 8;
  localparam logic [7:0]  DELIM_VAL = 8'hD5;
endpackage

// File: rtl/mii_nibble_pair.sv
module mii_nibble_pair #(
  parameter int unsigned NW = 4,
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] rxd_i,
  input  logic          dv_i,
  output logic [BW-1:0] byte_o,
  output logic          byte_stb_o
);
  localparam int unsigned LANES = BW / NW;
  localparam int unsigned CW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LANES - 1);

  logic [CW-1:0] cnt_q;
  logic [NW-1:0] nib_q [LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!dv_i)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // stored lanes hold earlier nibbles; the top lane is taken live
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g < LANES - 1) begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           nib_q[g] <= '0;
        else if (dv_i && cnt_q == CW'(g))      nib_q[g] <= rxd_i;
      end
      assign byte_o[g*NW +: NW] = nib_q[g];
    end else begin : g_live
      assign nib_q[g] = rxd_i;
      assign byte_o[g*NW +: NW] = rxd_i;
    end
  end

  assign byte_stb_o = dv_i && (cnt_q == LAST);

  p_phase_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dv_i |=> (cnt_q == '0));
endmodule

// File: rtl/mii_sfd_gate.sv
module mii_sfd_gate #(
  parameter int unsigned BW    = 8,
  parameter logic [BW-1:0] DELIM = 8'hD5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dv_i,
  input  logic [BW-1:0] byte_i,
  input  logic          byte_stb_i,
  output logic [BW-1:0] data_o,
  output logic          valid_o,
  output logic          start_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      start_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      start_o <= 1'b0;
      if (!dv_i) begin
        seen_q <= 1'b0;
      end else if (byte_stb_i) begin
        if (seen_q) begin
          data_o  <= byte_i;
          valid_o <= 1'b1;
        end else if (byte_i == DELIM) begin
          seen_q  <= 1'b1;
          start_o <= 1'b1;
        end
      end
    end
  end

  p_valid_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_start_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_start_not_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && valid_o));
endmodule

// File: rtl/mii_dv_edge.sv
module mii_dv_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dv_i,
  input  logic er_i,
  output logic end_o,
  output logic err_o
);
  logic dv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q  <= 1'b0;
      end_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      dv_q  <= dv_i;
      end_o <= dv_q && !dv_i;
      err_o <= er_i;
    end
  end

  p_end_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);
endmodule

// File: rtl/mii_rx_assembler.sv
module mii_rx_assembler
  import mii_rx_pkg::*;
#(
  parameter int unsigned   NW    = NIBBLE_W,
  parameter int unsigned   BW    = BYTE_W,
  parameter logic [BW-1:0] DELIM = DELIM_VAL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] rxd_i,
  input  logic          rx_dv_i,
  input  logic          rx_er_i,
  output logic [BW-1:0] data_o,
  output logic          valid_o,
  output logic          frame_start_o,
  output logic          frame_end_o,
  output logic          rx_error_o
);
  logic [BW-1:0] asm_byte;
  logic          asm_stb;

  mii_nibble_pair #(.NW(NW), .BW(BW)) u_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rxd_i      (rxd_i),
    .dv_i       (rx_dv_i),
    .byte_o     (asm_byte),
    .byte_stb_o (asm_stb)
  );

  mii_sfd_gate #(.BW(BW), .DELIM(DELIM)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dv_i       (rx_dv_i),
    .byte_i     (asm_byte),
    .byte_stb_i (asm_stb),
    .data_o     (data_o),
    .valid_o    (valid_o),
    .start_o    (frame_start_o)
  );

  mii_dv_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dv_i   (rx_dv_i),
    .er_i   (rx_er_i),
    .end_o  (frame_end_o),
    .err_o  (rx_error_o)
  );

  p_end_no_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> !valid_o);
  p_idle_no_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_dv_i |=> !valid_o && !frame_start_o);
endmodule

// File: tb/mii_rx_assembler_tb_top.sv
module mii_rx_assembler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rxd = 4'h0;
  logic       dv = 1'b0;
  logic       er = 1'b0;
  logic [7:0] data;
  logic       valid, fstart, fend, rerr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mii_rx_assembler dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .rx_dv_i(dv), .rx_er_i(er),
    .data_o(data), .valid_o(valid), .frame_start_o(fstart),
    .frame_end_o(fend), .rx_error_o(rerr)
  );

  // behavioural reference
  int m_phase = 0, m_low = 0, m_seen = 0, m_dvp = 0;
  int e_valid = 0, e_data = 0, e_start = 0, e_end = 0, e_err = 0;
  byte unsigned got_q[$];
  int starts = 0, ends = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_low = 0; m_seen = 0; m_dvp = 0;
      e_valid = 0; e_start = 0; e_end = 0; e_err = 0;
    end else begin
      int b;
      e_valid = 0; e_start = 0;
      e_end = (m_dvp != 0 && !dv) ? 1 : 0;
      e_err = er;
      if (dv) begin
        if (m_phase != 0) begin
          b = rxd * 16 + m_low;
          if (m_seen != 0) begin e_valid = 1; e_data = b; end
          else if (b == 8'hD5) begin e_start = 1; m_seen = 1; end
          m_phase = 0;
        end else begin
          m_low = rxd; m_phase = 1;
        end
      end else begin
        m_phase = 0; m_seen = 0;
      end
      m_dvp = dv;
    end
  end

  task automatic fail(string req, string what, int act, int exp);
    miscompares++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  always @(negedge clk) if (rst_n) begin
    vectors++;
    if (valid !== e_valid[0]) fail("R3", "valid_o", valid, e_valid);
    if (e_valid != 0 && data !== e_data[7:0]) fail("R2", "data_o", data, e_data);
    if (fstart !== e_start[0]) fail("R5", "frame_start_o", fstart, e_start);
    if (fend !== e_end[0]) fail("R7", "frame_end_o", fend, e_end);
    if (rerr !== e_err[0]) fail("R9", "rx_error_o", rerr, e_err);
    if (valid) got_q.push_back(data);
    if (fstart) starts++;
    if (fend) ends++;
  end

  task automatic nib(input logic [3:0] n, input logic e = 1'b0);
    @(negedge clk); dv = 1'b1; rxd = n; er = e;
  endtask
  task automatic send_byte(input logic [7:0] b, input logic e = 1'b0);
    nib(b[3:0], e); nib(b[7:4], e);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); dv = 1'b0; er = 1'b0; rxd = 4'h0; end
  endtask

  task automatic check_frame(string req, byte unsigned exp[$], int exp_starts);
    vectors++;
    if (got_q.size() != exp.size()) fail(req, "byte count", got_q.size(), exp.size());
    else foreach (exp[i]) if (got_q[i] != exp[i]) fail(req, "payload byte", got_q[i], exp[i]);
    vectors++;
    if (starts != exp_starts) fail(req, "start pulses", starts, exp_starts);
    vectors++;
    if (ends != 1) fail("R7", "end pulses", ends, 1);
    got_q.delete(); starts = 0; ends = 0;
  endtask

  initial begin
    byte unsigned pl[$];
    repeat (3) @(negedge clk);
    vectors++;  // R1 reset state
    if ({data, valid, fstart, fend, rerr} !== '0) fail("R1", "outputs in reset", {data, valid, fstart, fend, rerr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    if ({valid, fstart, fend, rerr} !== '0) fail("R1", "outputs after reset", {valid, fstart, fend, rerr}, 0);

    // R2 R4 R5: full preamble, nibble order
    for (int i = 0; i < 7; i++) send_byte(8'h55);
    send_byte(8'hD5);
    pl = '{8'h00, 8'h1B, 8'hC4, 8'hA7, 8'h3E};
    foreach (pl[i]) send_byte(pl[i]);
    idle(4);
    check_frame("R2", pl, 1);

    // R6: payload carries the delimiter value; R4 short preamble with stray byte
    send_byte(8'h55); send_byte(8'h12); send_byte(8'hD5);
    pl = '{8'hD5, 8'h99, 8'hD5};
    foreach (pl[i]) send_byte(pl[i]);
    idle(3);
    check_frame("R6", pl, 1);

    // R7: next frame needs its own delimiter
    send_byte(8'h55); send_byte(8'h77); send_byte(8'hD5); send_byte(8'h42);
    idle(3);
    pl = '{8'h42};
    check_frame("R7", pl, 1);

    // R8: odd nibble count, then a normal frame for alignment
    send_byte(8'h55); send_byte(8'hD5); send_byte(8'h81); send_byte(8'h6F);
    nib(4'hA);
    idle(3);
    pl = '{8'h81, 8'h6F};
    check_frame("R8", pl, 1);
    send_byte(8'h55); send_byte(8'hD5); send_byte(8'h2C);
    idle(3);
    pl = '{8'h2C};
    check_frame("R8", pl, 1);

    // R10: no delimiter at all
    for (int i = 0; i < 6; i++) send_byte(8'h55);
    send_byte(8'h5D);
    idle(3);
    pl = {};
    check_frame("R10", pl, 0);

    // R9: error burst during payload
    send_byte(8'h55); send_byte(8'hD5); send_byte(8'hE0, 1'b1); send_byte(8'h0E);
    idle(3);
    pl = '{8'hE0, 8'h0E};
    check_frame("R9", pl, 1);

    idle(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule